// File: doc/BRIEF.md
# Byte-Lane Even Parity Generator and Checker

This block sits between a 32-bit data path and an external bus that carries one parity bit per data byte. During a write cycle it computes even parity for every byte of the data word, drives the result onto the parity lines and enables their drivers. During a read cycle it releases the parity lines, and it recomputes parity from the sampled data when the cycle-complete strobe arrives. It compares that parity with the sampled parity lines, but only on the byte lanes whose enable is set.

A mismatch on any enabled lane pulls the active-low check output low for exactly one clock, in the cycle that follows the accepted read. The result goes nowhere else. The data path and the parity driven on the bus are not affected by a detected error. The surrounding logic decides whether the check output raises an interrupt.

Top module: `bytelane_parity`

## Requirements
- R1: For every lane i (lane i covers `bus_data[8*i+7 : 8*i]`, lane 0 the least significant byte), `par_out[i]` makes the count of ones in that byte plus the parity bit even. This holds combinationally in every cycle.
- R2: `par_oe` is 1 whenever `cyc_write` is 1 (write cycle) and 0 whenever `cyc_write` is 0 (read cycle), so the parity lines are released during reads.
- R3: When `cyc_ready` is 1 and `cyc_write` is 0 at a rising clock edge, `chk_n` is 0 in the following cycle if at least one lane has `lane_en[i]` = 1 and `par_in[i]` differing from the even parity of its byte. Otherwise `chk_n` is 1.
- R4: A lane with `lane_en[i]` = 0 never causes `chk_n` to go low, whatever its data and parity. Enable bit i gates exactly the lane that covers bits 8*i+7 down to 8*i.
- R5: After a failing read, `chk_n` returns to 1 one cycle later unless the next edge also accepts a failing read. Each accepted failing read gives exactly one low cycle.
- R6: Edges where `cyc_ready` is 0, and edges that complete a write cycle, leave `chk_n` at 1 in the following cycle.
- R7: When `rst_n` is 0 at a rising edge, `chk_n` is 1 in the following cycle, even if a failing read is presented at that edge.
- R8: A detected error has no other effect. In the cycle after a failing read, `par_out` and `par_oe` still follow R1 and R2 for the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 32 | Data word of the current cycle: write data, or sampled read data |
| lane_en | input | 4 | Active-high byte-lane enables; bit i selects byte i |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_ready | input | 1 | Cycle-complete strobe; the cycle is accepted at the edge where it is 1 |
| par_in | input | 4 | Parity lines as sampled from the bus |
| par_out | output | 4 | Generated even parity, one bit per byte lane |
| par_oe | output | 1 | Output enable for the parity line drivers |
| chk_n | output | 1 | Active-low parity-check pulse |

## Verification
The bench builds the block with its default parameters: four lanes of eight bits. With that size it can go through all sixteen enable masks, each combined with a corruption on every single lane. This covers every pairing of an enabled or disabled lane with a parity fault, and it shows that each enable bit gates its own byte and no other. The same size keeps the cases with several faulty lanes, back-to-back failing reads and a reset that coincides with a failing read short enough to run directly.

// File: rtl/bytepar_pkg.sv
// Package: shared types and defaults for the byte-lane parity block.
// Assumes a one-bit direction indicator where 1 means write.
package bytepar_pkg;

    localparam int DEF_LANE_W = 8;
    localparam int DEF_LANES  = 4;

    typedef enum logic {
        CYC_READ  = 1'b0,
        CYC_WRITE = 1'b1
    } cyc_dir_t;

endpackage

// File: rtl/bytepar_lane_gen.sv
// Module: computes even parity for each byte lane of a data word.
// Assumes the lanes are contiguous and lane 0 holds the least significant bits.
module bytepar_lane_gen #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DW    = LANE_W * LANES
) (
    input  logic [DW-1:0]    data,
    output logic [LANES-1:0] parity
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Reduction XOR yields the bit that makes each lane's count of ones even.
        assign parity[g] = ^data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bytepar_lane_cmp.sv
// Module: compares expected parity against sampled parity on the enabled lanes.
// Assumes the enables are active high; a disabled lane never reports a mismatch.
module bytepar_lane_cmp #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] expect_par,
    input  logic [LANES-1:0] seen_par,
    input  logic [LANES-1:0] lane_en,
    output logic             any_bad
);

    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        // A lane is faulty only when it is enabled and its parity bit differs.
        assign lane_bad[g] = lane_en[g] & (expect_par[g] ^ seen_par[g]);
    end

    // Combine the lane results into a single error indication.
    assign any_bad = |lane_bad;

endmodule

// File: rtl/bytepar_flag_reg.sv
// Module: registers the active-low check pulse for one cycle after an accepted read.
// Assumes a synchronous active-low reset; the idle level of the output is 1.
module bytepar_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_rd,
    input  logic any_bad,
    output logic flag_n
);

    // Capture the check result of the read accepted at this edge; otherwise go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b1;
        end else begin
            flag_n <= ~(accept_rd & any_bad);
        end
    end

endmodule

// File: rtl/bytelane_parity.sv
// Module: byte-lane even parity generator and checker for a split parity bus.
// Drives parity and its output enable on writes, releases the lines on reads,
// and pulses chk_n low for one cycle after a read with a faulty enabled lane.
// Assumes bus_data carries the write data on writes and the sampled data on reads.
module bytelane_parity #(
    parameter int LANE_W = bytepar_pkg::DEF_LANE_W,
    parameter int LANES  = bytepar_pkg::DEF_LANES,
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    bus_data,
    input  logic [LANES-1:0] lane_en,
    input  logic             cyc_write,
    input  logic             cyc_ready,
    input  logic [LANES-1:0] par_in,
    output logic [LANES-1:0] par_out,
    output logic             par_oe,
    output logic             chk_n
);

    import bytepar_pkg::*;

    cyc_dir_t         dir;
    logic [LANES-1:0] gen_par;
    logic             any_bad;
    logic             accept_rd;

    // Decode the direction indicator into the cycle type.
    assign dir       = cyc_dir_t'(cyc_write);
    assign accept_rd = cyc_ready & (dir == CYC_READ);

    bytepar_lane_gen #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_gen (
        .data   (bus_data),
        .parity (gen_par)
    );

    bytepar_lane_cmp #(
        .LANES      (LANES)
    ) u_cmp (
        .expect_par (gen_par),
        .seen_par   (par_in),
        .lane_en    (lane_en),
        .any_bad    (any_bad)
    );

    bytepar_flag_reg u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_rd (accept_rd),
        .any_bad   (any_bad),
        .flag_n    (chk_n)
    );

    // Present the generated parity; enable the drivers only during writes.
    assign par_out = gen_par;
    assign par_oe  = (dir == CYC_WRITE);

endmodule

// File: rtl/bytelane_parity_chk.sv
// Module: assertion checker bound to bytelane_parity.
// Assumes the same parameters as the design it observes.
module bytelane_parity_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DW    = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    bus_data,
    input logic [LANES-1:0] lane_en,
    input logic             cyc_write,
    input logic             cyc_ready,
    input logic [LANES-1:0] par_in,
    input logic [LANES-1:0] par_out,
    input logic             par_oe,
    input logic             chk_n
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_prop
        // R1: each driven lane together with its parity bit has an even count of ones.
        assert_even_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({par_out[g], bus_data[g*LANE_W +: LANE_W]}) % 2 == 0);
    end

    // R2: the drivers are released during read cycles.
    assert_release_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_write |-> !par_oe);

    // R3: a low check output is always preceded by an accepted read.
    assert_low_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_n |-> $past(cyc_ready && !cyc_write));

    // R4: a read with every lane disabled never flags.
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ready && !cyc_write && lane_en == '0) |=> chk_n);

    // R6: completing a write never flags.
    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ready && cyc_write) |=> chk_n);

    // R6: an edge without the ready strobe never flags.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_ready |=> chk_n);

    // R8: a detected error leaves the driver enable tracking the direction.
    assert_no_side_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_n && cyc_write) |-> par_oe);

endmodule

bind bytelane_parity bytelane_parity_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_data  (bus_data),
    .lane_en   (lane_en),
    .cyc_write (cyc_write),
    .cyc_ready (cyc_ready),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .chk_n     (chk_n)
);

// File: tb/bytelane_parity_bench.sv
// Bench: directed tests for bytelane_parity, one task per scenario.
`timescale 1ns/1ps
module bytelane_parity_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_data = '0;
    logic [3:0]  lane_en = '0;
    logic        cyc_write = 1'b0;
    logic        cyc_ready = 1'b0;
    logic [3:0]  par_in = '0;
    logic [3:0]  par_out;
    logic        par_oe;
    logic        chk_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bytelane_parity u_bytelane_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .lane_en   (lane_en),
        .cyc_write (cyc_write),
        .cyc_ready (cyc_ready),
        .par_in    (par_in),
        .par_out   (par_out),
        .par_oe    (par_oe),
        .chk_n     (chk_n)
    );

    // Expected even parity of a word, computed bit by bit.
    function automatic logic [3:0] ref_par(input logic [31:0] d);
        logic [3:0] p;
        p = '0;
        for (int l = 0; l < 4; l++) begin
            for (int b = 0; b < 8; b++) p[l] = p[l] ^ d[l*8 + b];
        end
        return p;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7: reset state, including a failing read held during reset.
    task automatic t_reset();
        rst_n = 1'b0;
        bus_data = 32'h0000_0001; par_in = 4'h0; lane_en = 4'hF;
        cyc_write = 1'b0; cyc_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(chk_n, 1, "R7 chk_n held high in reset");
        cyc_ready = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(chk_n, 1, "R7 chk_n high after reset");
    endtask

    // R1/R2: generated parity and driver enable on write data patterns.
    task automatic t_write_gen();
        logic [31:0] pats [5] = '{32'h0, 32'hFFFF_FFFF, 32'h0102_0408, 32'h8000_0001, 32'hA5C3_7E19};
        cyc_write = 1'b1; cyc_ready = 1'b0; lane_en = 4'hF;
        for (int i = 0; i < 5; i++) begin
            bus_data = pats[i];
            #1;
            check(par_out, ref_par(pats[i]), "R1 write parity");
            check(par_oe, 1, "R2 oe on write");
        end
        cyc_write = 1'b0;
        #1;
        check(par_oe, 0, "R2 oe released on read");
        @(negedge clk);
    endtask

    // R3/R4/R5: one read with the given corruption and enables, then an idle cycle.
    task automatic read_once(input logic [31:0] d, input logic [3:0] bad, input logic [3:0] en,
                             input string tag);
        logic exp_low;
        exp_low = |(bad & en);
        bus_data = d; par_in = ref_par(d) ^ bad; lane_en = en;
        cyc_write = 1'b0; cyc_ready = 1'b1;
        @(negedge clk);
        check(chk_n, !exp_low, tag);
        cyc_ready = 1'b0;
        @(negedge clk);
        check(chk_n, 1, "R5 pulse lasts one cycle");
    endtask

    // R4: every enable mask against a fault on every single lane.
    task automatic t_lane_sweep();
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 4; l++) begin
                read_once(32'h1234_5678 + m, 4'(1 << l), 4'(m), "R3 R4 lane gating");
            end
        end
        read_once(32'hDEAD_BEEF, 4'hF, 4'h0, "R4 all disabled, all bad");
        read_once(32'hDEAD_BEEF, 4'h0, 4'hF, "R3 clean read");
        read_once(32'hCAFE_0000, 4'h6, 4'h9, "R4 bad only on disabled lanes");
        read_once(32'hCAFE_0000, 4'hA, 4'hF, "R3 two bad lanes");
    endtask

    // R6: write completion and idle edges with mismatching lines never flag.
    task automatic t_quiet();
        bus_data = 32'h0F0F_1111; par_in = ~ref_par(32'h0F0F_1111); lane_en = 4'hF;
        cyc_write = 1'b1; cyc_ready = 1'b1;
        @(negedge clk);
        check(chk_n, 1, "R6 write completion quiet");
        cyc_write = 1'b0; cyc_ready = 1'b0;
        @(negedge clk);
        check(chk_n, 1, "R6 idle read quiet");
    endtask

    // R5/R8: back-to-back failing reads, then an error seen alongside a write.
    task automatic t_back_to_back();
        bus_data = 32'h0000_00FF; par_in = ref_par(32'h0000_00FF) ^ 4'h1; lane_en = 4'h1;
        cyc_write = 1'b0; cyc_ready = 1'b1;
        @(negedge clk);
        check(chk_n, 0, "R5 first failing read");
        bus_data = 32'h0100_0000; par_in = ref_par(32'h0100_0000) ^ 4'h8; lane_en = 4'h8;
        @(negedge clk);
        check(chk_n, 0, "R5 second failing read");
        bus_data = 32'h7700_0003; cyc_write = 1'b1; cyc_ready = 1'b0;
        #1;
        check(par_out, ref_par(32'h7700_0003), "R8 parity during error");
        check(par_oe, 1, "R8 oe during error");
        @(negedge clk);
        check(chk_n, 1, "R5 returns high");
        cyc_write = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_gen();
        t_lane_sweep();
        t_quiet();
        t_back_to_back();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule